// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of 2-bit saturating counters. A short global history register records the outcomes of the branches resolved most recently. A lookup combines the word index of the branch address with that history. The branch address picks a group of counters, and the history picks one counter inside the group. The most significant bit of that counter is the prediction. Because the history selects the counter, the recent behaviour of nearby branches changes which counter a branch uses. This lets the predictor learn patterns that a single counter per branch cannot follow.

The lookup side is combinational. It returns the prediction together with the history value that was used. The pipeline carries that history value forward and sends it back with the resolved outcome. This means the update trains exactly the counter that made the prediction, even when other branches have shifted the history in the meantime. Each update also shifts its actual outcome into the global history. With the default parameters the table holds 1024 counters: 256 address groups of 4 counters each.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history is 0, so every lookup predicts not taken and `lk_hist` reads 0.
- R2: `lk_pred` is bit 1 of the counter at index {`lk_pc`[IDX_W+1:2], current history}, where the history forms the low HIST_W bits of the index. 1 means taken.
- R3: `lk_pc`/`up_pc` bits [1:0] and the bits above IDX_W+1 do not affect which counter is used. Addresses that differ only there alias to the same group.
- R4: An update with `up_taken`=1 increments the selected counter and saturates at 3. An update with `up_taken`=0 decrements it and saturates at 0.
- R5: Each accepted update shifts `up_taken` into bit 0 of the history, and the old bit 0 moves to bit 1. With no update the history holds. `lk_hist` always shows the current history.
- R6: An update changes only the single counter at {`up_pc`[IDX_W+1:2], `up_hist`}. Every other counter, including the other history contexts of the same address group, keeps its value.
- R7: The update index uses the supplied `up_hist`, not the current history register.
- R8: When a lookup and an update hit the same counter in one cycle, the lookup returns the value from before the update. The new value is visible from the next cycle.
- R9: A counter at 3 needs two not-taken updates before its prediction becomes not taken. A counter at 0 needs two taken updates before its prediction becomes taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | Global history used by this lookup |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | HIST_W | History value returned from the lookup of this branch |

## Verification
A wrong counter value does not show up on its own. It appears at `lk_pred` only when a lookup reaches that exact address group while the history holds that exact context, and only if the fault crosses the 1/2 boundary. For this reason the bench compares every cycle against a model of the whole table, and it sweeps every group under every history value. A wrong history shift corrupts `lk_hist` in the cycle after the update. It then misdirects every later lookup. A wrong index or a missing saturation stays hidden until a second update pushes the counter across the boundary, so the runs repeat the same outcome well past saturation.

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_pred,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_hist
);
  localparam int TBL_W = IDX_W + HIST_W;
  localparam int DEPTH = 1 << TBL_W;

  logic [1:0]        ctr [DEPTH];
  logic [HIST_W-1:0] ghr;
  logic [TBL_W-1:0]  rd_idx, wr_idx;
  logic [1:0]        wr_cur, wr_nxt;
  logic              unused_bits;

  assign rd_idx  = {lk_pc[IDX_W+1:2], ghr};
  assign wr_idx  = {up_pc[IDX_W+1:2], up_hist};
  assign lk_pred = ctr[rd_idx][1];
  assign lk_hist = ghr;
  assign wr_cur  = ctr[wr_idx];

  always_comb begin
    if (up_taken) wr_nxt = (wr_cur == 2'b11) ? wr_cur : wr_cur + 2'b01;
    else          wr_nxt = (wr_cur == 2'b00) ? wr_cur : wr_cur - 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr[i] <= 2'b01;
      ghr <= '0;
    end else if (up_valid) begin
      ctr[wr_idx] <= wr_nxt;
      ghr <= HIST_W'({ghr, up_taken});
    end
  end

  assign unused_bits = ^{lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0],
                         up_pc[PC_W-1:IDX_W+2], up_pc[1:0]};
endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
  parameter int HIST_W = 2,
  parameter int TBL_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic              lk_pred,
  input logic [HIST_W-1:0] lk_hist,
  input logic [TBL_W-1:0]  rd_idx,
  input logic [TBL_W-1:0]  wr_idx,
  input logic [1:0]        wr_cur,
  input logic [1:0]        wr_nxt
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!lk_pred && lk_hist == '0)); // R1
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(up_valid)) |-> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)})); // R5
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(up_valid)) |-> $stable(lk_hist)); // R5
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |-> (wr_nxt >= wr_cur)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken) |-> (wr_nxt <= wr_cur)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(up_valid) && wr_idx == $past(wr_idx)) |-> wr_cur == $past(wr_nxt)); // R6
  AST_SAME_CYCLE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && rd_idx == wr_idx) |-> lk_pred == wr_cur[1]); // R8
endmodule

bind corr_bpred corr_bpred_chk #(.HIST_W(HIST_W), .TBL_W(TBL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
  .lk_pred(lk_pred), .lk_hist(lk_hist), .rd_idx(rd_idx), .wr_idx(wr_idx),
  .wr_cur(wr_cur), .wr_nxt(wr_nxt));

// File: tb/corr_bpred_tb_top.sv
`timescale 1ns/1ps
module corr_bpred_tb_top;
  localparam int IW = 4;
  localparam int HW = 2;
  localparam int NENT = 1 << IW;
  localparam int NCTR = 1 << (IW + HW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 1'b0, up_taken = 1'b0;
  logic [HW-1:0] up_hist = '0;
  logic lk_pred;
  logic [HW-1:0] lk_hist;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int mdl [NCTR];
  logic [HW-1:0] mghr;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  corr_bpred #(.PC_W(32), .IDX_W(IW), .HIST_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist));

  function automatic int cidx(input logic [31:0] pc, input logic [HW-1:0] h);
    return int'((pc >> 2) & (NENT - 1)) * (1 << HW) + int'(h);
  endfunction

  function automatic logic nextbit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic step(input string tag, input logic [31:0] lpc, input logic uv,
                      input logic [31:0] upc, input logic ut, input logic [HW-1:0] uh);
    logic exp_p;
    int k;
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_hist = uh;
    #1;
    exp_p = (mdl[cidx(lpc, mghr)] >= 2);
    n_chk++;
    if (lk_pred !== exp_p) begin
      n_bad++;
      $display("FAIL %s pred pc=%h: actual %b expected %b", tag, lpc, lk_pred, exp_p);
    end
    n_chk++;
    if (lk_hist !== mghr) begin
      n_bad++;
      $display("FAIL R5 history: actual %b expected %b", lk_hist, mghr);
    end
    @(posedge clk);
    if (uv) begin
      k = cidx(upc, uh);
      if (ut && mdl[k] < 3) mdl[k]++;
      if (!ut && mdl[k] > 0) mdl[k]--;
      mghr = {mghr[HW-2:0], ut};
    end
  endtask

  initial begin
    for (int i = 0; i < NCTR; i++) mdl[i] = 1;
    mghr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state across all groups
    for (int e = 0; e < NENT; e++) step("R1", 32'(e << 2), 1'b0, '0, 1'b0, '0);

    // R4 R9: saturation at 3, then hysteresis down to 0 and back up
    for (int i = 0; i < 6; i++) step("R4", 32'h14, 1'b1, 32'h14, 1'b1, 2'b11);
    step("R9", 32'h14, 1'b0, 32'h14, 1'b0, 2'b11);
    step("R9", 32'h14, 1'b1, 32'h14, 1'b0, 2'b11);
    step("R9", 32'h14, 1'b1, 32'h14, 1'b0, 2'b11);
    step("R9", 32'h14, 1'b1, 32'h14, 1'b0, 2'b00);
    step("R9", 32'h14, 1'b0, 32'h14, 1'b0, 2'b00);
    for (int i = 0; i < 6; i++) step("R4", 32'h14, 1'b1, 32'h14, 1'b0, 2'b00);
    step("R9", 32'h14, 1'b1, 32'h14, 1'b1, 2'b00);
    step("R9", 32'h14, 1'b0, 32'h14, 1'b0, 2'b00);

    // R3: aliasing through ignored address bits
    for (int k = 0; k < 16; k++)
      step("R3", 32'h14 | 32'(k << (IW + 2)) | 32'(k & 3), 1'b1,
           32'h14 | 32'(k << (IW + 6)) | 32'((k + 1) & 3), nextbit(), mghr);

    // R7: update history differs from current history
    for (int k = 0; k < 24; k++)
      step("R7", 32'h28, 1'b1, 32'h28, nextbit(), mghr ^ 2'b11);

    // R8: same-cycle lookup and update to the same counter
    for (int k = 0; k < 32; k++)
      step("R8", 32'h3C, 1'b1, 32'h3C, nextbit(), mghr);

    // R6: train each group and context, then read back everything
    for (int h = 0; h < 4; h++)
      for (int e = 0; e < NENT; e++)
        step("R6", 32'(((e + 1) % NENT) << 2), 1'b1, 32'(e << 2), nextbit(), 2'(h));
    for (int e = 0; e < NENT; e++) step("R6", 32'(e << 2), 1'b0, '0, 1'b0, '0);

    // R2: alternating and loop patterns in every group
    for (int e = 0; e < NENT; e++) begin
      for (int i = 0; i < 16; i++)
        step("R2", 32'(e << 2), 1'b1, 32'(e << 2), 1'(i & 1), mghr);
      for (int i = 0; i < 16; i++)
        step("R2", 32'(e << 2), 1'b1, 32'(e << 2), (i % 4) != 3, mghr);
    end
    // R2: every context of every group read out
    for (int h = 0; h < 4; h++) begin
      step("R2", '0, 1'b1, 32'h0, h[1], mghr);
      step("R2", '0, 1'b1, 32'h0, h[0], mghr);
      for (int e = 0; e < NENT; e++) step("R2", 32'(e << 2), 1'b0, '0, 1'b0, '0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule